// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block gathers interrupt requests for a CPU and decides which one is serviced next. There are three kinds of request: sixteen maskable sources, one nonmaskable pin and a software trap. Each maskable source is edge-detected into its own request flag. Each has a mask bit and a one-bit programmed priority, where 1 means high and 0 means low. Among requests at the same programmed priority, the source with the lower index wins.

The CPU raises `ackReq` when it can take an interrupt. In that same cycle the block answers with `ackGrant`, the source number and the 16-bit vector address of the winner. At the clock edge that ends the cycle, the flag of the granted source is cleared. For maskable and nonmaskable grants the service level is also pushed onto an in-service stack three entries deep. A return pulse pops that stack. A return marked as a trap return leaves the stack alone, because trap entries are never pushed; this is what lets the trap nest inside itself.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A maskable request flag is set by a 0-to-1 transition on its `srcIn` bit. An input held high after its request was acknowledged raises no further request.
- R2: A maskable source with its flag set is granted only if all of these hold: `gie`=1, its mask bit is 0, and its service level is above `isrLevel`. The service level is 2 for a high-priority source and 1 for a low-priority one.
- R3: If several maskable sources are eligible in the same cycle, a high-priority source beats a low-priority one. Among sources with equal priority, the lowest index wins.
- R4: A maskable source k is granted with `srcId`=k and `vecAddr`=0x0006+2k. The nonmaskable request is granted with `srcId`=16 and `vecAddr`=0x0002. The trap is granted with `srcId`=17 and `vecAddr`=0x003E. With no grant, both outputs are 0.
- R5: A rising edge on `nmiIn` leaves a pending request. This request ignores `gie` and all masks, and it is granted ahead of every maskable source. It is held back only while `isrLevel`=3, and stays pending until then.
- R6: While `trapReq`=1, every `ackReq` is granted to the trap, even with `gie`=0, even ahead of a pending nonmaskable request, and even at `isrLevel`=3. A trap grant leaves `isrLevel` unchanged, so the trap can be taken again inside its own handler.
- R7: A grant clears the flag of the granted source. If a new rising edge on that same source arrives in the grant cycle, the flag stays set.
- R8: A maskable or nonmaskable grant pushes its level onto the in-service stack: 1 for low priority, 2 for high priority, 3 for nonmaskable. `isrLevel` shows the top of the stack, or 0 when the stack is empty.
- R9: A `retPulse` with `retTrap`=0 pops the stack, and a pop on an empty stack is ignored. A `retPulse` with `retTrap`=1 leaves `isrLevel` unchanged. If a return and a grant fall in the same cycle, the pop is applied before the push.
- R10: `ackGrant` is high only in a cycle where `ackReq` is high and at least one request is eligible.
- R11: After reset, all flags are clear, all sources are masked, all priorities are low, no nonmaskable request is pending and `isrLevel`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gie | input | 1 | Global enable for maskable sources |
| srcIn | input | 16 | Maskable request inputs, rising-edge detected |
| nmiIn | input | 1 | Nonmaskable request pin, rising-edge detected |
| trapReq | input | 1 | Software trap request |
| maskWe | input | 1 | Mask register write strobe |
| maskIn | input | 16 | Mask write data, 1 = masked |
| prioWe | input | 1 | Priority register write strobe |
| prioIn | input | 16 | Priority write data, 1 = high |
| ackReq | input | 1 | CPU ready to take an interrupt |
| ackGrant | output | 1 | A request is granted this cycle |
| vecAddr | output | 16 | Vector address of the granted request |
| srcId | output | 5 | Granted source, 0-15 maskable, 16 nonmaskable, 17 trap |
| retPulse | input | 1 | Handler return |
| retTrap | input | 1 | Qualifies `retPulse` as a trap return |
| isrLevel | output | 2 | Current in-service level |

## Verification
Two same-cycle collisions are checked.

The first is a grant coinciding with a fresh edge on the same source. The bench raises that source's input again in the very cycle `ackReq` takes it. Once a return frees the level, a second grant of that source must follow, and after that no further request may remain.

The second is a grant coinciding with a normal return. With a low-priority handler active, the bench raises `retPulse` together with `ackReq` for a pending high-priority source. `isrLevel` must then show 2 with a stack one entry deep, so that a single further return brings it to 0.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  parameter int SRC_COUNT = 16;
  parameter int ID_W = $clog2(SRC_COUNT + 2);
  parameter int LVL_W = 2;
  parameter int VEC_W = 16;

  localparam logic [LVL_W-1:0] LVL_LOW  = 2'd1;
  localparam logic [LVL_W-1:0] LVL_HIGH = 2'd2;
  localparam logic [LVL_W-1:0] LVL_NMI  = 2'd3;

  localparam logic [ID_W-1:0] ID_NMI  = ID_W'(SRC_COUNT);
  localparam logic [ID_W-1:0] ID_TRAP = ID_W'(SRC_COUNT + 1);

  typedef struct packed {
    logic                 push;
    logic                 pop;
    logic [LVL_W-1:0]     pushLvl;
    logic [SRC_COUNT-1:0] clrMask;
    logic                 clrNmi;
  } ctrlStrobe_t;

  function automatic logic [ID_W-1:0] lowestIdx(input logic [SRC_COUNT-1:0] v);
    logic [ID_W-1:0] r;
    r = '0;
    for (int i = SRC_COUNT - 1; i >= 0; i--) begin
      if (v[i]) r = ID_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_vec_datapath.sv
module irq_vec_datapath
  import irq_vec_pkg::*;
#(
  parameter int STACK_DEPTH = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SRC_COUNT-1:0] srcIn,
  input  logic                 nmiIn,
  input  logic                 maskWe,
  input  logic [SRC_COUNT-1:0] maskIn,
  input  logic                 prioWe,
  input  logic [SRC_COUNT-1:0] prioIn,
  input  ctrlStrobe_t          strobes,
  output logic [SRC_COUNT-1:0] reqFlags,
  output logic [SRC_COUNT-1:0] maskBits,
  output logic [SRC_COUNT-1:0] prioBits,
  output logic                 nmiPend,
  output logic [LVL_W-1:0]     curLevel
);
  localparam int DEPTH_W = $clog2(STACK_DEPTH + 1);

  logic [SRC_COUNT-1:0] srcPrev;
  logic                 nmiPrev;
  logic [SRC_COUNT-1:0] srcRise;
  logic                 nmiRise;
  logic [LVL_W-1:0]     stackMem [STACK_DEPTH];
  logic [DEPTH_W-1:0]   depth;
  logic [DEPTH_W-1:0]   depthAfterPop;

  assign srcRise = srcIn & ~srcPrev;
  assign nmiRise = nmiIn & ~nmiPrev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srcPrev  <= '0;
      nmiPrev  <= 1'b0;
      reqFlags <= '0;
      nmiPend  <= 1'b0;
      maskBits <= '1;
      prioBits <= '0;
    end else begin
      srcPrev  <= srcIn;
      nmiPrev  <= nmiIn;
      reqFlags <= (reqFlags & ~strobes.clrMask) | srcRise;
      nmiPend  <= (nmiPend & ~strobes.clrNmi) | nmiRise;
      if (maskWe) maskBits <= maskIn;
      if (prioWe) prioBits <= prioIn;
    end
  end

  always_comb begin
    depthAfterPop = depth;
    if (strobes.pop && depth != '0) depthAfterPop = depth - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth <= '0;
    end else if (strobes.push && depthAfterPop < DEPTH_W'(STACK_DEPTH)) begin
      depth <= depthAfterPop + 1'b1;
    end else begin
      depth <= depthAfterPop;
    end
  end

  for (genvar k = 0; k < STACK_DEPTH; k++) begin : g_stack
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stackMem[k] <= '0;
      end else if (strobes.push && depthAfterPop == DEPTH_W'(k)) begin
        stackMem[k] <= strobes.pushLvl;
      end
    end
  end

  always_comb begin
    curLevel = '0;
    for (int k = 0; k < STACK_DEPTH; k++) begin
      if (depth == DEPTH_W'(k + 1)) curLevel = stackMem[k];
    end
  end
endmodule

// File: rtl/irq_vec_control.sv
module irq_vec_control
  import irq_vec_pkg::*;
#(
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h0006,
  parameter logic [VEC_W-1:0] VEC_NMI  = 16'h0002,
  parameter logic [VEC_W-1:0] VEC_TRAP = 16'h003E
) (
  input  logic                 gie,
  input  logic                 trapReq,
  input  logic                 ackReq,
  input  logic                 retPulse,
  input  logic                 retTrap,
  input  logic [SRC_COUNT-1:0] reqFlags,
  input  logic [SRC_COUNT-1:0] maskBits,
  input  logic [SRC_COUNT-1:0] prioBits,
  input  logic                 nmiPend,
  input  logic [LVL_W-1:0]     curLevel,
  output ctrlStrobe_t          strobes,
  output logic                 ackGrant,
  output logic [VEC_W-1:0]     vecAddr,
  output logic [ID_W-1:0]      srcId
);
  logic [SRC_COUNT-1:0] liveReq;
  logic [SRC_COUNT-1:0] hiCand;
  logic [SRC_COUNT-1:0] loCand;
  logic                 hiOk;
  logic                 loOk;
  logic                 trapWin;
  logic                 nmiWin;
  logic                 maskWin;
  logic [ID_W-1:0]      winIdx;

  assign liveReq = gie ? (reqFlags & ~maskBits) : '0;
  assign hiCand  = liveReq & prioBits;
  assign loCand  = liveReq & ~prioBits;
  assign hiOk    = (|hiCand) && (curLevel < LVL_HIGH);
  assign loOk    = (|loCand) && (curLevel < LVL_LOW);

  assign trapWin = ackReq && trapReq;
  assign nmiWin  = ackReq && !trapReq && nmiPend && (curLevel != LVL_NMI);
  assign maskWin = ackReq && !trapReq && !nmiWin && (hiOk || loOk);
  assign winIdx  = hiOk ? lowestIdx(hiCand) : lowestIdx(loCand);

  always_comb begin
    strobes         = '0;
    strobes.pop     = retPulse && !retTrap;
    ackGrant        = trapWin || nmiWin || maskWin;
    vecAddr         = '0;
    srcId           = '0;
    if (trapWin) begin
      vecAddr = VEC_TRAP;
      srcId   = ID_TRAP;
    end else if (nmiWin) begin
      vecAddr         = VEC_NMI;
      srcId           = ID_NMI;
      strobes.push    = 1'b1;
      strobes.pushLvl = LVL_NMI;
      strobes.clrNmi  = 1'b1;
    end else if (maskWin) begin
      vecAddr                 = VEC_BASE + VEC_W'({winIdx, 1'b0});
      srcId                   = winIdx;
      strobes.push            = 1'b1;
      strobes.pushLvl         = hiOk ? LVL_HIGH : LVL_LOW;
      strobes.clrMask[winIdx] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int STACK_DEPTH = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 gie,
  input  logic [SRC_COUNT-1:0] srcIn,
  input  logic                 nmiIn,
  input  logic                 trapReq,
  input  logic                 maskWe,
  input  logic [SRC_COUNT-1:0] maskIn,
  input  logic                 prioWe,
  input  logic [SRC_COUNT-1:0] prioIn,
  input  logic                 ackReq,
  output logic                 ackGrant,
  output logic [VEC_W-1:0]     vecAddr,
  output logic [ID_W-1:0]      srcId,
  input  logic                 retPulse,
  input  logic                 retTrap,
  output logic [LVL_W-1:0]     isrLevel
);
  ctrlStrobe_t          strobes;
  logic [SRC_COUNT-1:0] reqFlags;
  logic [SRC_COUNT-1:0] maskBits;
  logic [SRC_COUNT-1:0] prioBits;
  logic                 nmiPend;

  irq_vec_datapath #(.STACK_DEPTH(STACK_DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .srcIn(srcIn), .nmiIn(nmiIn),
    .maskWe(maskWe), .maskIn(maskIn), .prioWe(prioWe), .prioIn(prioIn),
    .strobes(strobes), .reqFlags(reqFlags), .maskBits(maskBits),
    .prioBits(prioBits), .nmiPend(nmiPend), .curLevel(isrLevel)
  );

  irq_vec_control u_ctl (
    .gie(gie), .trapReq(trapReq), .ackReq(ackReq), .retPulse(retPulse),
    .retTrap(retTrap), .reqFlags(reqFlags), .maskBits(maskBits),
    .prioBits(prioBits), .nmiPend(nmiPend), .curLevel(isrLevel),
    .strobes(strobes), .ackGrant(ackGrant), .vecAddr(vecAddr), .srcId(srcId)
  );
endmodule

// File: rtl/irq_vector_ctrl_checker.sv
module irq_vector_ctrl_checker
  import irq_vec_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             gie,
  input logic             trapReq,
  input logic             ackReq,
  input logic             ackGrant,
  input logic [VEC_W-1:0] vecAddr,
  input logic [ID_W-1:0]  srcId,
  input logic             retPulse,
  input logic             retTrap,
  input logic [LVL_W-1:0] isrLevel
);
  a_r10_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    ackGrant |-> ackReq);

  a_r6_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ackReq && trapReq) |-> (ackGrant && srcId == ID_TRAP && vecAddr == 16'h003E));

  a_r2_mask_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (ackGrant && srcId < ID_NMI) |-> gie);

  a_r8_mask_level_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (ackGrant && srcId < ID_NMI && !retPulse) |=> (isrLevel > $past(isrLevel)));

  a_r8_nmi_level: assert property (@(posedge clk) disable iff (!rst_n)
    (ackGrant && srcId == ID_NMI) |=> (isrLevel == LVL_NMI));

  a_r4_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (ackGrant && srcId == ID_NMI) |-> (vecAddr == 16'h0002));

  a_r9_trap_return_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (retPulse && retTrap && !(ackGrant && srcId != ID_TRAP)) |=> $stable(isrLevel));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_checker chk (.*);

// File: tb/irq_vector_ctrl_test.sv
`timescale 1ns/1ps
module irq_vector_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gie = 1'b0;
  logic [15:0] srcIn = '0;
  logic        nmiIn = 1'b0;
  logic        trapReq = 1'b0;
  logic        maskWe = 1'b0;
  logic [15:0] maskIn = '0;
  logic        prioWe = 1'b0;
  logic [15:0] prioIn = '0;
  logic        ackReq = 1'b0;
  logic        ackGrant;
  logic [15:0] vecAddr;
  logic [4:0]  srcId;
  logic        retPulse = 1'b0;
  logic        retTrap = 1'b0;
  logic [1:0]  isrLevel;

  int nRun = 0;
  int nFail = 0;
  bit gotG;
  logic [4:0]  gotId;
  logic [15:0] gotVec;

  always #10 clk = ~clk;

  irq_vector_ctrl uut (.*);

  typedef struct packed {
    logic [15:0] mask;
    logic [15:0] prio;
    logic [15:0] pulses;
    logic        en;
    logic        expG;
    logic [4:0]  expId;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{16'h0000, 16'h0000, 16'h0005, 1'b1, 1'b1, 5'd0},
    '{16'h0000, 16'h0004, 16'h0005, 1'b1, 1'b1, 5'd2},
    '{16'h0001, 16'h0000, 16'h0003, 1'b1, 1'b1, 5'd1},
    '{16'h0000, 16'h0000, 16'h0001, 1'b0, 1'b0, 5'd0},
    '{16'hFFFF, 16'h0000, 16'hFFFF, 1'b1, 1'b0, 5'd0},
    '{16'h0000, 16'hC000, 16'hC000, 1'b1, 1'b1, 5'd14},
    '{16'h0000, 16'h0000, 16'h8000, 1'b1, 1'b1, 5'd15},
    '{16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b0, 5'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    rst_n = 1'b0; srcIn = '0; nmiIn = 1'b0; trapReq = 1'b0; ackReq = 1'b0;
    retPulse = 1'b0; retTrap = 1'b0; maskWe = 1'b0; prioWe = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic setCfg(input logic [15:0] m, input logic [15:0] p);
    maskWe = 1'b1; maskIn = m; prioWe = 1'b1; prioIn = p;
    tick();
    maskWe = 1'b0; prioWe = 1'b0;
  endtask

  task automatic pulseSrc(input logic [15:0] s);
    srcIn = s; tick(); srcIn = '0; tick();
  endtask

  task automatic pulseNmi();
    nmiIn = 1'b1; tick(); nmiIn = 1'b0; tick();
  endtask

  task automatic tryAck();
    ackReq = 1'b1;
    #1;
    gotG = ackGrant; gotId = srcId; gotVec = vecAddr;
    tick();
    ackReq = 1'b0;
  endtask

  task automatic doRet(input logic trapKind);
    retPulse = 1'b1; retTrap = trapKind;
    tick();
    retPulse = 1'b0; retTrap = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R11: reset state, all sources masked
    doReset();
    check("R11 level", 32'(isrLevel), 0);
    gie = 1'b1;
    pulseSrc(16'h0001);
    tryAck();
    check("R11 masked after reset", 32'(gotG), 0);

    // Table walk: R2 R3 R4 R10
    for (int i = 0; i < NV; i++) begin
      doReset();
      gie = TBL[i].en;
      setCfg(TBL[i].mask, TBL[i].prio);
      pulseSrc(TBL[i].pulses);
      tryAck();
      check("R10 R2 grant", 32'(gotG), 32'(TBL[i].expG));
      if (TBL[i].expG) begin
        check("R3 winner", 32'(gotId), 32'(TBL[i].expId));
        check("R4 vector", 32'(gotVec), 32'h6 + 32'(TBL[i].expId) * 2);
      end else begin
        check("R4 idle vector", 32'(gotVec), 0);
      end
    end

    // Nesting R5 R6 R8 R9
    doReset();
    gie = 1'b1;
    setCfg(16'h0000, 16'h0008);
    pulseSrc(16'h0003);
    tryAck();
    check("R4 id0", 32'(gotId), 0);
    check("R8 low level", 32'(isrLevel), 1);
    tryAck();
    check("R2 low blocked at level 1", 32'(gotG), 0);
    pulseSrc(16'h0008);
    tryAck();
    check("R4 vec src3", 32'(gotVec), 32'h000C);
    check("R8 high level", 32'(isrLevel), 2);
    pulseNmi();
    tryAck();
    check("R5 nmi id", 32'(gotId), 16);
    check("R4 nmi vec", 32'(gotVec), 32'h0002);
    check("R8 nmi level", 32'(isrLevel), 3);
    pulseNmi();
    tryAck();
    check("R5 nmi blocked in nmi", 32'(gotG), 0);
    trapReq = 1'b1;
    tryAck();
    check("R6 trap at level 3", 32'(gotVec), 32'h003E);
    check("R6 trap keeps level", 32'(isrLevel), 3);
    tryAck();
    check("R6 trap re-entry", 32'(gotId), 17);
    trapReq = 1'b0;
    doRet(1'b1);
    check("R9 trap return keeps", 32'(isrLevel), 3);
    doRet(1'b0);
    check("R9 pop to 2", 32'(isrLevel), 2);
    tryAck();
    check("R5 pending nmi later", 32'(gotId), 16);
    doRet(1'b0);
    doRet(1'b0);
    check("R9 pop to 1", 32'(isrLevel), 1);
    doRet(1'b0);
    tryAck();
    check("R2 low now granted", 32'(gotId), 1);
    doRet(1'b0);
    doRet(1'b0);
    check("R9 empty pop", 32'(isrLevel), 0);

    // R5 R6 with gie off, trap beats nmi
    doReset();
    gie = 1'b0;
    pulseNmi();
    trapReq = 1'b1;
    tryAck();
    check("R6 trap beats nmi", 32'(gotId), 17);
    trapReq = 1'b0;
    tryAck();
    check("R5 nmi with gie off", 32'(gotId), 16);

    // R1 level held
    doReset();
    gie = 1'b1;
    setCfg(16'h0000, 16'h0000);
    srcIn = 16'h0010;
    tick(); tick();
    tryAck();
    check("R1 held grant", 32'(gotId), 4);
    doRet(1'b0);
    tick();
    tryAck();
    check("R1 held no repeat", 32'(gotG), 0);
    srcIn = '0;

    // R7 collision of grant and new edge
    doReset();
    gie = 1'b1;
    setCfg(16'h0000, 16'h0000);
    pulseSrc(16'h0020);
    srcIn = 16'h0020;
    tryAck();
    srcIn = '0;
    check("R7 first grant", 32'(gotId), 5);
    doRet(1'b0);
    tryAck();
    check("R7 kept flag", 32'(gotId), 5);
    doRet(1'b0);
    tryAck();
    check("R7 flag cleared", 32'(gotG), 0);

    // R9 return and grant same cycle
    doReset();
    gie = 1'b1;
    setCfg(16'h0000, 16'h0004);
    pulseSrc(16'h0001);
    tryAck();
    pulseSrc(16'h0004);
    retPulse = 1'b1;
    tryAck();
    retPulse = 1'b0;
    check("R9 same-cycle grant", 32'(gotId), 2);
    check("R9 pop before push", 32'(isrLevel), 2);
    doRet(1'b0);
    check("R9 single entry", 32'(isrLevel), 0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule